// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This controller turns on three supply rails in a fixed order and turns them off in the reverse order. A sequencing request input, `en`, may be asynchronous. A single-cycle pulse input, `tick`, paces all delays: every delay is a whole number of tick periods counted on the system clock. The three outputs are enable levels for downstream regulators. `rail_en[0]` is rail 1, `rail_en[1]` is rail 2 and `rail_en[2]` is rail 3.

When the request rises, rail 1 comes on after a lead delay that is aligned to the tick stream. Rails 2 and 3 then follow, each after a shorter fixed step. When the request falls, the rails that are on go off from the highest one down.

The controller also covers three irregular cases. A request that drops before rail 1 comes on is discarded cleanly. A request that drops part way through power-up turns into a reverse shutdown of only the rails already on. A request that returns during power-down waits until every rail is off and then starts power-up again from zero. A polarity input inverts all three outputs for regulators with active-low enables.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, every rail is inactive and `busy` is low. Tick pulses have no effect while the request is low. A rail is active when `rail_en[i]` equals NOT `inv`.
- R2: The request is synchronised and its rising edge is detected. From that edge, rail 1 becomes active on the 10th tick pulse (LEAD_TICKS). This is 9 to 10 tick periods, depending on the tick phase.
- R3: Rail 2 becomes active on the 8th tick (STEP_TICKS) after the tick that activated rail 1. Rail 3 becomes active on the 8th tick after that.
- R4: A falling request after full power-up starts a power-down. Rail 3 goes inactive on the 10th tick. Rail 2 goes inactive 8 ticks later, and rail 1 goes inactive 8 ticks after rail 2.
- R5: A request that falls before rail 1 is active returns the controller to idle with all rails inactive. A later power-up needs a new rising edge and counts from zero again.
- R6: A request that falls with only rails 1..k active stops all further activations. The highest active rail goes inactive on the 10th tick, and each lower rail goes inactive 8 ticks after the one above it.
- R7: A rising request during power-down does not interrupt it. Once all rails are inactive, power-up restarts with the lead count from zero.
- R8: With `inv` high, each output bit is the inverse of its active state. Sequencing order and timing are the same for both polarities.
- R9: `busy` is high while a power-up or power-down count is running. It is low when idle and when all rails are on.
- R10: Tick pulses while all rails are on and the request is held high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timing pulse |
| en | input | 1 | Sequencing request, may be asynchronous |
| inv | input | 1 | Output polarity invert |
| rail_en | output | NUM_RAILS | Registered rail enables; bit 0 is rail 1 |
| busy | output | 1 | A sequencing delay count is running |

## Verification
The bench builds the controller with its default parameters: three rails, a lead of ten ticks, a step of eight ticks and a two-stage synchroniser. Ticks come every six clocks, so every complete sequence, abort, partial shutdown and re-request during power-down fits in a few thousand cycles. Each transition is checked at the tick just before it and at the tick that causes it. This makes an off-by-one error in either delay count visible.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RISE = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_FALL = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rail_seq_sync.sv
module rail_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == target - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (tick)          cnt <= done ? '0 : cnt + CW'(1);
  end

  // R2/R3: the count never reaches its target without having fired
  a_r2_cnt_below_target: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < target));
  // R3: a completed delay restarts the next one from zero
  a_r3_done_restarts: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt == '0));
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int N  = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_s,
  input  logic          en_rise,
  input  logic          done,
  output seq_state_t    state,
  output logic [LW-1:0] level,
  output logic          first_drop,
  output logic          clr
);
  assign clr = (state == SQ_RISE) && !en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      level      <= '0;
      first_drop <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (en_rise) state <= SQ_RISE;
        SQ_RISE: begin
          if (!en_s) begin
            if (level == '0) state <= SQ_IDLE;
            else begin
              state      <= SQ_FALL;
              first_drop <= 1'b1;
            end
          end else if (done) begin
            level <= level + LW'(1);
            if (level == LW'(N-1)) state <= SQ_HOLD;
          end
        end
        SQ_HOLD: if (!en_s) begin
          state      <= SQ_FALL;
          first_drop <= 1'b1;
        end
        SQ_FALL: if (done) begin
          level      <= level - LW'(1);
          first_drop <= 1'b0;
          if (level == LW'(1)) state <= en_s ? SQ_RISE : SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R1: idle means no rail is on
  a_r1_idle_empty: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> (level == '0));
  // R3/R4: rails change one at a time
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |->
      ((level == $past(level) + LW'(1)) || (level + LW'(1) == $past(level))));
  // R5: early drop aborts to idle
  a_r5_abort_clean: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_RISE && level == '0 && !en_s) |=> (state == SQ_IDLE && level == '0));
  // R6: no release during shutdown
  a_r6_fall_monotonic: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FALL) |=> (level <= $past(level)));
  // R7: re-request seen at end of power-down restarts power-up
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FALL && done && level == LW'(1) && en_s) |=> (state == SQ_RISE && level == '0));
endmodule

// File: rtl/rail_seq_outdrv.sv
module rail_seq_outdrv #(
  parameter int N  = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inv,
  input  logic [LW-1:0] level,
  output logic [N-1:0]  rail_q
);
  logic [N-1:0] act;

  for (genvar i = 0; i < N; i++) begin : g_therm
    assign act[i] = (level > LW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) rail_q <= {N{inv}};
    else     rail_q <= act ^ {N{inv}};
  end

  // R8: after removing polarity, outputs always form a thermometer code
  a_r8_thermometer: assert property (@(posedge clk) disable iff (rst)
    (((rail_q ^ {N{$past(inv)}}) & ((rail_q ^ {N{$past(inv)}}) + N'(1))) == '0));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int LEAD_TICKS  = 10,
  parameter int STEP_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 en,
  input  logic                 inv,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 busy
);
  localparam int MAXT = (LEAD_TICKS > STEP_TICKS) ? LEAD_TICKS : STEP_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int LW   = $clog2(NUM_RAILS + 1);

  logic          en_s, en_q, en_rise;
  logic          done, clr, run, first_drop, long_sel;
  logic [CW-1:0] target;
  logic [LW-1:0] level;
  seq_state_t    state;

  rail_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(en), .q(en_s));

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_s;
  end
  assign en_rise = en_s && !en_q;

  assign run      = (state == SQ_RISE) || (state == SQ_FALL);
  assign long_sel = ((state == SQ_RISE) && (level == '0)) ||
                    ((state == SQ_FALL) && first_drop);
  assign target   = long_sel ? CW'(LEAD_TICKS) : CW'(STEP_TICKS);

  rail_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(run), .clr(clr), .tick(tick),
    .target(target), .done(done));

  rail_seq_fsm #(.N(NUM_RAILS), .LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .en_s(en_s), .en_rise(en_rise), .done(done),
    .state(state), .level(level), .first_drop(first_drop), .clr(clr));

  rail_seq_outdrv #(.N(NUM_RAILS), .LW(LW)) u_out (
    .clk(clk), .rst(rst), .inv(inv), .level(level), .rail_q(rail_en));

  assign busy = run;

  // R10: with all rails on and the request high, nothing moves
  a_r10_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_HOLD && en_s) |=> (state == SQ_HOLD && level == LW'(NUM_RAILS)));
endmodule

// File: tb/rail_seq_ctrl_test.sv
`timescale 1ns/1ps
module rail_seq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       inv = 1'b0;
  logic [2:0] rail_en;
  logic       busy;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  rail_seq_ctrl uut (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .inv(inv),
    .rail_en(rail_en), .busy(busy));

  task automatic chk(string tag, logic [2:0] act, logic bexp);
    logic [2:0] raw;
    raw = act ^ {3{inv}};
    checks++;
    if (rail_en !== raw || busy !== bexp) begin
      errors++;
      $display("FAIL %s rails act=%b exp=%b busy act=%b exp=%b",
               tag, rail_en, raw, busy, bexp);
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_en(logic v);
    en = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset", 3'b000, 1'b0);
    ticks(12);
    chk("R1 ticks while idle", 3'b000, 1'b0);
  endtask

  task automatic t_power_up;
    set_en(1'b1);
    chk("R9 busy during lead", 3'b000, 1'b1);
    ticks(9);  chk("R2 before 10th tick", 3'b000, 1'b1);
    ticks(1);  chk("R2 rail1 on", 3'b001, 1'b1);
    ticks(7);  chk("R3 before rail2", 3'b001, 1'b1);
    ticks(1);  chk("R3 rail2 on", 3'b011, 1'b1);
    ticks(7);  chk("R3 before rail3", 3'b011, 1'b1);
    ticks(1);  chk("R3 rail3 on", 3'b111, 1'b0);
    ticks(5);  chk("R10 steady all on", 3'b111, 1'b0);
  endtask

  task automatic t_power_down;
    set_en(1'b0);
    chk("R9 busy during fall", 3'b111, 1'b1);
    ticks(9);  chk("R4 before rail3 off", 3'b111, 1'b1);
    ticks(1);  chk("R4 rail3 off", 3'b011, 1'b1);
    ticks(7);  chk("R4 before rail2 off", 3'b011, 1'b1);
    ticks(1);  chk("R4 rail2 off", 3'b001, 1'b1);
    ticks(7);  chk("R4 before rail1 off", 3'b001, 1'b1);
    ticks(1);  chk("R4 rail1 off", 3'b000, 1'b0);
  endtask

  task automatic t_abort;
    set_en(1'b1);
    ticks(6);  chk("R5 mid lead", 3'b000, 1'b1);
    set_en(1'b0);
    chk("R5 aborted to idle", 3'b000, 1'b0);
    ticks(12); chk("R5 stays idle", 3'b000, 1'b0);
    set_en(1'b1);
    ticks(9);  chk("R5 fresh count from zero", 3'b000, 1'b1);
    ticks(1);  chk("R5 rail1 after fresh rise", 3'b001, 1'b1);
    set_en(1'b0);
    ticks(9);  chk("R6 single rail held", 3'b001, 1'b1);
    ticks(1);  chk("R6 single rail off", 3'b000, 1'b0);
  endtask

  task automatic t_partial;
    set_en(1'b1);
    ticks(10); chk("R2 partial rail1", 3'b001, 1'b1);
    ticks(8);  chk("R3 partial rail2", 3'b011, 1'b1);
    set_en(1'b0);
    ticks(4);  chk("R6 no rail3 after drop", 3'b011, 1'b1);
    ticks(5);  chk("R6 before top off", 3'b011, 1'b1);
    ticks(1);  chk("R6 rail2 off", 3'b001, 1'b1);
    ticks(7);  chk("R6 before rail1 off", 3'b001, 1'b1);
    ticks(1);  chk("R6 rail1 off", 3'b000, 1'b0);
  endtask

  task automatic t_rerise;
    set_en(1'b1);
    ticks(26); chk("R7 setup all on", 3'b111, 1'b0);
    set_en(1'b0);
    ticks(3);
    set_en(1'b1);
    ticks(6);  chk("R7 fall continues", 3'b111, 1'b1);
    ticks(1);  chk("R7 rail3 off", 3'b011, 1'b1);
    ticks(8);  chk("R7 rail2 off", 3'b001, 1'b1);
    ticks(8);  chk("R7 all off then restart", 3'b000, 1'b1);
    ticks(9);  chk("R7 restart lead not done", 3'b000, 1'b1);
    ticks(1);  chk("R7 restart rail1 on", 3'b001, 1'b1);
    set_en(1'b0);
    ticks(10); chk("R7 cleanup", 3'b000, 1'b0);
  endtask

  task automatic t_invert;
    inv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle inverted", 3'b000, 1'b0);
    t_power_up;
    t_power_down;
    inv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 polarity restored", 3'b000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    t_power_up;
    t_power_down;
    t_abort;
    t_partial;
    t_rerise;
    t_invert;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule